// File: doc/BRIEF.md
# Paired-Group ADC Conversion and Readout Sequencer

This block sits on the host side of a six-channel simultaneous-sampling converter. The converter has three active-low conversion-start lines, one busy flag and a 16-bit parallel data bus. Software logic above the block supplies a 3-bit group mask and a one-cycle start request. The block then drives a start pulse on the selected lines and waits for the converter's busy flag to fall. It then reads back one result for every channel in a triggered group, using chip-select and read strobes.

Each start line covers one pair of channels. Mask bit 0 selects channels 1–2, bit 1 selects channels 3–4 and bit 2 selects channels 5–6. Results leave the block in ascending channel order on a valid/ready stream, each tagged with a 3-bit channel index. A static mode input switches between full-width word reads and half-width byte reads, where each result takes two strobes. A one-cycle done pulse marks the acceptance of the final result of a cycle. A separate one-cycle error pulse reports a conversion that never finished.

Top module: `adc_grab_ctrl`

## Requirements
- R1: Out of reset, and whenever no start pulse is in progress, all three start lines (`cnv_n`), `cs_n` and `rd_n` sit high. A start pulse drives low exactly the lines whose mask bit is set, for `START_LOW_CYC` cycles. Those lines then return high together, and the other lines stay high throughout.
- R2: Result tags are channel indices equal to the channel number minus one. Mask bit g enables indices 2g and 2g+1, so bit 0 gives indices 0–1, bit 1 gives 2–3 and bit 2 gives 4–5.
- R3: No read strobe falls while the busy input is high, and reading begins only after a high-to-low transition of busy is seen following the start pulse. No start line is pulsed again before that cycle of conversion and readout has ended.
- R4: If busy has not fallen within `TMO_CYC` cycles of the start lines rising, the block raises `tmo_err` for exactly one cycle. It then returns to idle with no strobes and no done pulse. With the default parameters, `TMO_CYC` is 1000.
- R5: A cycle returns exactly as many results as there are channels in the triggered groups, and returns them in ascending index order. Channels of untriggered groups are never read.
- R6: When `byte_mode` is 0, each result takes one read strobe, and its 16-bit value is `bus_d` as sampled at the end of that strobe.
- R7: When `byte_mode` is 1, each result takes two read strobes. The first strobe supplies the high byte and the second supplies the low byte, both from `bus_d[7:0]`. Bits 15:8 of the bus are ignored.
- R8: Each read strobe holds `rd_n` low for exactly `RD_LOW_CYC` cycles. `cs_n` is low whenever `rd_n` is low. Consecutive strobes within one readout are separated by at least `RD_GAP_CYC` cycles with `rd_n` high.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_chan` stay unchanged.
- R10: `done` is high for exactly one cycle. It appears in the cycle after the last result of a cycle is accepted.
- R11: A start request is taken only when the block is idle, and the mask is captured at that moment. Later changes of `grp_mask` do not affect the running cycle. A request with an all-zero mask produces no start pulse, no chip-select and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request a conversion cycle (taken when idle) |
| grp_mask | input | 3 | Channel-pair groups to convert; bit g covers indices 2g, 2g+1 |
| byte_mode | input | 1 | 0: one 16-bit read per result; 1: two 8-bit reads, high byte first |
| cnv_n | output | 3 | Active-low conversion-start lines, one per group |
| busy | input | 1 | Converter busy flag; falling edge marks end of conversion |
| cs_n | output | 1 | Active-low chip select for the readout |
| rd_n | output | 1 | Active-low read strobe |
| bus_d | input | 16 | Converter parallel data bus |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | 16 | Assembled conversion result |
| res_chan | output | 3 | Channel index of the result (channel number minus one) |
| done | output | 1 | One-cycle pulse after the last result is accepted |
| tmo_err | output | 1 | One-cycle pulse when busy fails to fall in time |

## Verification
Two events can land in the same cycle: a start request that is held high, and the handshake that accepts the last result of a running cycle. To provoke this, the bench keeps `start_req` asserted for an entire cycle and changes `grp_mask` while the readout is still running. The bench then judges three things. Only the first, latched mask may be converted and read. The request must have no effect until `done` has pulsed. The new mask's start lines must go low in the cycle that directly follows the done pulse.

// File: rtl/adc_grab_pkg.sv
// Shared types for the conversion/readout sequencer.
// Assumes nothing beyond being compiled before its users.
package adc_grab_pkg;

    // Sequencer phases, from request to final handshake.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CNV_LO = 3'd1,
        ST_WAIT   = 3'd2,
        ST_RD_LO  = 3'd3,
        ST_GAP    = 3'd4,
        ST_PUSH   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/adc_grab_tick.sv
// Down-counting interval timer shared by every timed phase of the sequencer.
// A load sets the count; expired is high once the count has reached zero,
// so loading N-1 keeps a phase alive for N cycles.
// Assumes load and a running count never need to coexist.
module adc_grab_tick #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag for the owning phase.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/adc_grab_chsel.sv
// Channel walker: expands the group mask to per-channel enables and finds
// the lowest enabled channel overall and the lowest one above the current.
// Assumes channels of a group are contiguous, PER_GRP wide.
module adc_grab_chsel #(
    parameter int NGRP    = 3,
    parameter int PER_GRP = 2,
    parameter int CW      = $clog2(NGRP * PER_GRP)
) (
    input  logic [NGRP-1:0] grp_en,
    input  logic [CW-1:0]   cur,
    output logic [CW-1:0]   first,
    output logic [CW-1:0]   next,
    output logic            has_next
);

    localparam int NCH = NGRP * PER_GRP;

    logic [NCH-1:0] ch_en;

    // Each group bit fans out to its channel slice.
    for (genvar g = 0; g < NGRP; g++) begin : g_fan
        assign ch_en[g*PER_GRP +: PER_GRP] = {PER_GRP{grp_en[g]}};
    end

    // Scan from the top down so the lowest matching index wins.
    always_comb begin
        first    = '0;
        next     = '0;
        has_next = 1'b0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (ch_en[k]) begin
                first = CW'(k);
                if (CW'(k) > cur) begin
                    next     = CW'(k);
                    has_next = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_grab_ctrl.sv
// Conversion and readout sequencer for a six-channel paired-group ADC.
// Pulses the selected start lines, waits for busy to fall (with timeout),
// then reads each enabled channel in ascending order in word or byte mode
// and streams tagged results out on valid/ready.
// Assumes busy and bus_d are already synchronous to clk and byte_mode is
// static while a cycle runs.
module adc_grab_ctrl #(
    parameter int CLK_MHZ       = 250,
    parameter int CONV_NS       = 3000,
    parameter int MARGIN_NS     = 1000,
    parameter int START_LOW_CYC = 4,
    parameter int RD_LOW_CYC    = 3,
    parameter int RD_GAP_CYC    = 2,
    parameter int NGRP          = 3,
    parameter int PER_GRP       = 2,
    parameter int DW            = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_req,
    input  logic [NGRP-1:0]                       grp_mask,
    input  logic                                  byte_mode,
    output logic [NGRP-1:0]                       cnv_n,
    input  logic                                  busy,
    output logic                                  cs_n,
    output logic                                  rd_n,
    input  logic [DW-1:0]                         bus_d,
    output logic                                  res_valid,
    input  logic                                  res_ready,
    output logic [DW-1:0]                         res_data,
    output logic [$clog2(NGRP*PER_GRP)-1:0]       res_chan,
    output logic                                  done,
    output logic                                  tmo_err
);
    import adc_grab_pkg::*;

    localparam int TMO_CYC = CLK_MHZ * (CONV_NS + MARGIN_NS) / 1000;
    localparam int M1      = (START_LOW_CYC > RD_LOW_CYC) ? START_LOW_CYC : RD_LOW_CYC;
    localparam int M2      = (M1 > RD_GAP_CYC) ? M1 : RD_GAP_CYC;
    localparam int MAXC    = (M2 > TMO_CYC) ? M2 : TMO_CYC;
    localparam int TW      = $clog2(MAXC + 1);
    localparam int CW      = $clog2(NGRP * PER_GRP);
    localparam int BW      = DW / 2;

    seq_state_t      st_q, st_d;
    logic [NGRP-1:0] mask_q;
    logic [CW-1:0]   ch_q;
    logic            hi_ph_q;
    logic [BW-1:0]   hi_q;
    logic [DW-1:0]   data_q;
    logic            busy_q, done_q, tmo_q;

    logic            tk_ld, tk_exp;
    logic [TW-1:0]   tk_val;
    logic            accept, begin_rd, take_hi, take_res, advance, fin, tmo_d;
    logic [CW-1:0]   ch_first, ch_next;
    logic            ch_more;

    adc_grab_tick #(.W(TW)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tk_ld),
        .load_val (tk_val),
        .expired  (tk_exp)
    );

    adc_grab_chsel #(.NGRP(NGRP), .PER_GRP(PER_GRP), .CW(CW)) chsel_i (
        .grp_en   (mask_q),
        .cur      (ch_q),
        .first    (ch_first),
        .next     (ch_next),
        .has_next (ch_more)
    );

    // Next-phase decision and timer reload for every phase.
    always_comb begin
        st_d     = st_q;
        tk_ld    = 1'b0;
        tk_val   = '0;
        accept   = 1'b0;
        begin_rd = 1'b0;
        take_hi  = 1'b0;
        take_res = 1'b0;
        advance  = 1'b0;
        fin      = 1'b0;
        tmo_d    = 1'b0;
        case (st_q)
            ST_IDLE: if (start_req && (grp_mask != '0)) begin
                accept = 1'b1;
                st_d   = ST_CNV_LO;
                tk_ld  = 1'b1;
                tk_val = TW'(START_LOW_CYC - 1);
            end
            ST_CNV_LO: if (tk_exp) begin
                st_d   = ST_WAIT;
                tk_ld  = 1'b1;
                tk_val = TW'(TMO_CYC - 1);
            end
            ST_WAIT: begin
                if (busy_q && !busy) begin
                    begin_rd = 1'b1;
                    st_d     = ST_RD_LO;
                    tk_ld    = 1'b1;
                    tk_val   = TW'(RD_LOW_CYC - 1);
                end else if (tk_exp) begin
                    tmo_d = 1'b1;
                    st_d  = ST_IDLE;
                end
            end
            ST_RD_LO: if (tk_exp) begin
                if (byte_mode && !hi_ph_q) begin
                    take_hi = 1'b1;
                    st_d    = ST_GAP;
                    tk_ld   = 1'b1;
                    tk_val  = TW'(RD_GAP_CYC - 1);
                end else begin
                    take_res = 1'b1;
                    st_d     = ST_PUSH;
                end
            end
            ST_GAP: if (tk_exp) begin
                st_d   = ST_RD_LO;
                tk_ld  = 1'b1;
                tk_val = TW'(RD_LOW_CYC - 1);
            end
            ST_PUSH: if (res_ready) begin
                if (ch_more) begin
                    advance = 1'b1;
                    st_d    = ST_GAP;
                    tk_ld   = 1'b1;
                    tk_val  = TW'(RD_GAP_CYC - 1);
                end else begin
                    fin  = 1'b1;
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase register, captured mask, channel pointer and data assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            mask_q  <= '0;
            ch_q    <= '0;
            hi_ph_q <= 1'b0;
            hi_q    <= '0;
            data_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            busy_q <= busy;
            done_q <= fin;
            tmo_q  <= tmo_d;
            if (accept)
                mask_q <= grp_mask;
            if (begin_rd) begin
                ch_q    <= ch_first;
                hi_ph_q <= 1'b0;
            end
            if (take_hi) begin
                hi_q    <= bus_d[BW-1:0];
                hi_ph_q <= 1'b1;
            end
            if (take_res)
                data_q <= byte_mode ? {hi_q, bus_d[BW-1:0]} : bus_d;
            if (advance) begin
                ch_q    <= ch_next;
                hi_ph_q <= 1'b0;
            end
        end
    end

    // Pin and stream outputs decoded from the registered phase.
    always_comb begin
        cnv_n     = (st_q == ST_CNV_LO) ? ~mask_q : '1;
        cs_n      = !((st_q == ST_RD_LO) || (st_q == ST_GAP) || (st_q == ST_PUSH));
        rd_n      = (st_q != ST_RD_LO);
        res_valid = (st_q == ST_PUSH);
        res_data  = data_q;
        res_chan  = ch_q;
        done      = done_q;
        tmo_err   = tmo_q;
    end

    // R1
    cnv_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cnv_n) & (~mask_q)) == '0);

    // R2
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_chan < CW'(NGRP * PER_GRP)));

    // R3
    rd_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !busy);

    // R4
    tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |=> (!tmo_err && cs_n && (cnv_n == '1)));

    // R8
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !res_valid));

endmodule

// File: tb/adc_grab_ctrl_tb_top.sv
// Directed bench: a behavioural converter model answers start pulses with a
// busy window and drives per-channel data on each read strobe.
module adc_grab_ctrl_tb_top;

    localparam int START_LOW = 4;
    localparam int RD_LOW    = 3;
    localparam int RD_GAP    = 2;
    localparam int TMO       = 1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_req;
    logic [2:0]  grp_mask;
    logic        byte_mode;
    logic [2:0]  cnv_n;
    logic        busy;
    logic        cs_n;
    logic        rd_n;
    logic [15:0] bus_d;
    logic        res_valid;
    logic        res_ready;
    logic [15:0] res_data;
    logic [2:0]  res_chan;
    logic        done;
    logic        tmo_err;

    int n_cmp = 0;
    int n_bad = 0;
    int seed  = 0;
    int cyc   = 0;

    // model state
    logic [2:0] cnv_prev;
    logic       rd_prev;
    logic [2:0] conv_grp;
    logic [2:0] last_pulse_grp;
    int  mdl_ch, busy_cnt;
    bit  mdl_ph, stuck, in_cs;
    int  cnv_lo_cnt, rd_lo_cnt, rd_hi_cnt;
    int  cnv_falls, rd_strobes, cs_low_cnt;
    int  cnv_len_err, cnv_busy_err, rd_busy_err, rd_len_err, gap_err, cs_err;

    adc_grab_ctrl #(
        .CLK_MHZ(250), .CONV_NS(3000), .MARGIN_NS(1000),
        .START_LOW_CYC(START_LOW), .RD_LOW_CYC(RD_LOW), .RD_GAP_CYC(RD_GAP),
        .NGRP(3), .PER_GRP(2), .DW(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .grp_mask(grp_mask),
        .byte_mode(byte_mode), .cnv_n(cnv_n), .busy(busy), .cs_n(cs_n),
        .rd_n(rd_n), .bus_d(bus_d), .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .res_chan(res_chan), .done(done), .tmo_err(tmo_err)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] val(input int ch, input int sd);
        return 16'((ch + 1) * 16'h1111) ^ 16'(sd * 16'h0203);
    endfunction

    function automatic int nxt(input logic [2:0] g, input int from);
        for (int k = from; k < 6; k++)
            if (g[k/2]) return k;
        return 7;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Converter model: busy window after a start pulse, data per read strobe,
    // plus pin-timing bookkeeping.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            cnv_prev <= 3'b111; rd_prev <= 1'b1;
            busy <= 1'b0; bus_d <= 16'h0;
            conv_grp = 3'b000; last_pulse_grp = 3'b000;
            mdl_ch = 7; mdl_ph = 0; busy_cnt = 0; in_cs = 0;
            cnv_lo_cnt = 0; rd_lo_cnt = 0; rd_hi_cnt = 0;
        end else begin
            if ((~cnv_n & cnv_prev) != 3'b000) begin
                cnv_falls++;
                if (busy) cnv_busy_err++;
            end
            if ((cnv_n & ~cnv_prev) != 3'b000) begin
                if (cnv_lo_cnt != START_LOW) cnv_len_err++;
                last_pulse_grp = cnv_n & ~cnv_prev;
                if (!busy) begin
                    conv_grp = cnv_n & ~cnv_prev;
                    mdl_ch   = nxt(conv_grp, 0);
                    mdl_ph   = 0;
                    busy     <= 1'b1;
                    busy_cnt = 60;
                end
            end else if (busy && !stuck) begin
                if (busy_cnt == 0) busy <= 1'b0;
                else busy_cnt--;
            end
            if (cnv_n != 3'b111) cnv_lo_cnt = cnv_lo_cnt + 1;
            else cnv_lo_cnt = 0;

            if (!cs_n) cs_low_cnt++;
            if (!rd_n && cs_n) cs_err++;
            if (!rd_n && rd_prev) begin
                rd_strobes++;
                if (busy) rd_busy_err++;
                if (in_cs && rd_hi_cnt < RD_GAP) gap_err++;
                if (mdl_ch > 5) bus_d <= 16'hDEAD;
                else if (byte_mode) begin
                    bus_d <= {8'hEE, mdl_ph ? val(mdl_ch, seed) : (val(mdl_ch, seed) >> 8)} ;
                    if (mdl_ph) mdl_ch = nxt(conv_grp, mdl_ch + 1);
                    mdl_ph = !mdl_ph;
                end else begin
                    bus_d <= val(mdl_ch, seed);
                    mdl_ch = nxt(conv_grp, mdl_ch + 1);
                end
            end
            if (rd_n && !rd_prev) begin
                if (rd_lo_cnt != RD_LOW) rd_len_err++;
                in_cs = 1;
            end
            if (!rd_n) rd_lo_cnt = rd_prev ? 1 : rd_lo_cnt + 1;
            else       rd_hi_cnt = !rd_prev ? 1 : rd_hi_cnt + 1;
            if (cs_n) in_cs = 0;
            cnv_prev <= cnv_n;
            rd_prev  <= rd_n;
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(negedge clk) begin
        if (cyc > 150000) begin
            chk(0, "WDOG", "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    task automatic model_clean(input string tag);
        chk(cnv_len_err == 0, "R1", {tag, " start pulse length"}, cnv_len_err, 0);
        chk(rd_busy_err == 0 && cnv_busy_err == 0, "R3",
            {tag, " strobe/start while busy"}, rd_busy_err + cnv_busy_err, 0);
        chk(rd_len_err == 0 && gap_err == 0 && cs_err == 0, "R8",
            {tag, " strobe timing"}, rd_len_err + gap_err + cs_err, 0);
    endtask

    // Consume one running cycle's results; checks tags, data, count, done.
    task automatic collect(input logic [2:0] m, input bit bm, input bit stall);
        int exp_ch[6];
        int n = 0, k = 0, acc_at = -10;
        int s0 = rd_strobes;
        bit seen_done = 0, held = 0;
        logic [15:0] hd;
        logic [2:0]  hc;
        for (int c = 0; c < 6; c++)
            if (m[c/2]) begin exp_ch[n] = c; n++; end
        for (int i = 0; i < 6000 && !seen_done; i++) begin
            @(negedge clk);
            if (held)
                chk(res_valid === 1'b1 && res_data === hd && res_chan === hc, "R9",
                    "stalled result changed", {res_chan, res_data}, {hc, hd});
            res_ready = stall ? (i % 3 != 0) : 1'b1;
            if (done) begin
                chk(k == n && acc_at == i - 1, "R10", "done placement", acc_at, i - 1);
                seen_done = 1;
            end
            if (res_valid && res_ready) begin
                if (k < n) begin
                    chk(res_chan == 3'(exp_ch[k]), "R2", "channel tag", res_chan, exp_ch[k]);
                    chk(res_data == val(exp_ch[k], seed), bm ? "R7" : "R6", "result data",
                        res_data, val(exp_ch[k], seed));
                end else
                    chk(0, "R5", "extra result", k + 1, n);
                k++;
                acc_at = i;
            end
            held = res_valid && !res_ready;
            hd = res_data;
            hc = res_chan;
        end
        res_ready = 1'b1;
        chk(seen_done, "R10", "done seen", seen_done, 1);
        chk(k == n, "R5", "result count", k, n);
        chk(rd_strobes - s0 == n * (bm ? 2 : 1), bm ? "R7" : "R6", "strobe count",
            rd_strobes - s0, n * (bm ? 2 : 1));
        chk(last_pulse_grp == m, "R1", "pulsed start lines", last_pulse_grp, m);
    endtask

    task automatic run_conv(input logic [2:0] m, input bit bm, input bit stall);
        seed++;
        @(negedge clk);
        byte_mode = bm;
        grp_mask  = m;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        collect(m, bm, stall);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
        model_clean("conv");
    endtask

    task automatic t_reset();
        chk(cnv_n == 3'b111 && cs_n && rd_n, "R1", "idle pins after reset",
            {cnv_n, cs_n, rd_n}, 5'b11111);
        chk(!res_valid && !done && !tmo_err, "R9", "idle stream after reset",
            {res_valid, done, tmo_err}, 0);
    endtask

    task automatic t_zero_mask();
        int f0 = cnv_falls, c0 = cs_low_cnt;
        bit any_valid = 0;
        @(negedge clk);
        grp_mask  = 3'b000;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (res_valid || done) any_valid = 1;
        end
        chk(cnv_falls == f0, "R11", "zero mask start pulses", cnv_falls - f0, 0);
        chk(cs_low_cnt == c0 && !any_valid, "R11", "zero mask bus activity",
            cs_low_cnt - c0, 0);
    endtask

    task automatic t_timeout();
        int s0 = rd_strobes, at = -1;
        bit got_done = 0;
        stuck = 1;
        seed++;
        @(negedge clk);
        byte_mode = 1'b0;
        grp_mask  = 3'b001;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int i = 1; i < TMO + 40 && at < 0; i++) begin
            @(negedge clk);
            if (done) got_done = 1;
            if (tmo_err) at = i;
        end
        chk(at >= TMO && at <= TMO + START_LOW + 4, "R4", "timeout cycle", at, TMO + START_LOW);
        @(negedge clk);
        chk(!tmo_err && cs_n, "R4", "error pulse width / idle", {tmo_err, cs_n}, 2'b01);
        chk(rd_strobes == s0 && !got_done, "R4", "no reads or done on timeout",
            rd_strobes - s0, 0);
        stuck = 0;
        repeat (100) @(negedge clk);
    endtask

    task automatic t_held_start();
        seed++;
        @(negedge clk);
        byte_mode = 1'b0;
        grp_mask  = 3'b001;
        start_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        grp_mask = 3'b110;
        begin
            int f0 = cnv_falls;
            collect(3'b001, 1'b0, 1'b1);
            chk(cnv_falls == f0, "R11", "start ignored while running", cnv_falls - f0, 0);
        end
        @(negedge clk);
        chk(cnv_n == 3'b001 && !done, "R11", "restart right after done", cnv_n, 3'b001);
        start_req = 1'b0;
        seed++;
        collect(3'b110, 1'b0, 1'b0);
        @(negedge clk);
        model_clean("held");
    endtask

    initial begin
        rst_n = 1'b0; start_req = 1'b0; grp_mask = 3'b000; byte_mode = 1'b0;
        res_ready = 1'b1; stuck = 0;
        cnv_falls = 0; rd_strobes = 0; cs_low_cnt = 0;
        cnv_len_err = 0; cnv_busy_err = 0; rd_busy_err = 0;
        rd_len_err = 0; gap_err = 0; cs_err = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_conv(3'b111, 1'b0, 1'b0);
        run_conv(3'b101, 1'b0, 1'b1);
        run_conv(3'b010, 1'b1, 1'b0);
        run_conv(3'b011, 1'b1, 1'b1);
        run_conv(3'b100, 1'b0, 1'b0);
        t_zero_mask();
        t_timeout();
        run_conv(3'b001, 1'b1, 1'b0);
        t_held_start();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule